// File: doc/BRIEF.md
# Per-Channel Averaging Accumulator with Sequence-End Gating

This block takes tagged conversion results from a round-robin channel sequencer and decides, channel by channel, whether each result goes to the channel's status register at once or is summed into a running total. A per-channel enable mask chooses which channels are averaged. One shared depth select sets the number of samples per mean for every averaged channel: 16, 64 or 256. Once a channel has collected that many samples, the block writes back the floor of their mean. Channels without averaging are still written on every conversion, interleaved with the averaged ones.

The block also gates the sequencer's end-of-pass flag into an end-of-sequence (EOS) pulse. While any channel is averaged, the pulse fires only after the full averaging depth of passes. The calibration channel follows its own rule. Its averaging is turned on by an active-low input. When it is on, the first calibration conversion updates the coefficients at once, and after that the coefficients update with the mean of every 16 conversions. A change to the depth select, the mask or the calibration control clears all running sums and the pass count.

Top module: `avg_seq_acc`

## Requirements
- R1: During reset and on the first cycles after it, st_we, cal_we and eos are all low.
- R2: A result on a non-calibration channel whose mask bit is 0 gives st_we one cycle later, with st_ch equal to that channel and st_val equal to the raw data.
- R3: When depth_sel is 01, 10 or 11 (N = 16, 64 or 256) and a channel's mask bit is 1, that channel gets st_we only on its Nth accumulated conversion. st_val is then floor(sum of those N samples / N).
- R4: With depth_sel 00 every non-calibration channel passes through as in R2, whatever the mask, and eos follows every pass_end.
- R5: eos is a one-cycle pulse one cycle after pass_end. While depth_sel is not 00 and at least one non-calibration mask bit is 1, it fires only on every Nth pass_end. Otherwise it fires on every pass_end.
- R6: Results on channel CAL_CH never raise st_we. With cal_avg_n = 1, each of them raises cal_we one cycle later, carrying the raw data.
- R7: With cal_avg_n = 0, the first calibration result after reset or after a configuration change is written on cal_we unchanged. Each following group of 16 calibration results is written once, as the floor of their mean.
- R8: A change of depth_sel, avg_mask or cal_avg_n clears every partial sum, every sample count, the calibration first-update flag and the pass count.
- R9: The avg_mask bit at position CAL_CH has no effect, either on calibration handling or on EOS gating.
- R10: 256 full-scale samples (16'hFFFF) average to 16'hFFFF without overflow.
- R11: Non-averaged channels keep updating on every pass while averaged channels accumulate in the same passes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| depth_sel | input | 2 | Shared averaging depth: 00 none, 01 16, 10 64, 11 256 |
| avg_mask | input | NUM_CH | Per-channel averaging enable, 1 = averaged |
| cal_avg_n | input | 1 | Calibration averaging enable, active low |
| res_valid | input | 1 | Conversion result strobe |
| res_ch | input | $clog2(NUM_CH) | Channel index of the result |
| res_data | input | DATA_W | Conversion result |
| pass_end | input | 1 | Sequencer end-of-pass strobe |
| st_we | output | 1 | Status register write strobe |
| st_ch | output | $clog2(NUM_CH) | Status register channel index |
| st_val | output | DATA_W | Status register value |
| cal_we | output | 1 | Calibration coefficient update strobe |
| cal_val | output | DATA_W | Calibration value |
| eos | output | 1 | End-of-sequence pulse |

## Verification
The bench builds the block with NUM_CH = 4 and CAL_CH = 3. Each pass then carries only four conversions, so a run of 256 passes that covers the deepest average, with both an averaged and a plain channel alongside the calibration channel, stays short. The bench sweeps every depth select, several masks including one that sets only the calibration bit, both calibration modes, full-scale data and a configuration change partway through a block. For every scenario it computes the expected write counts, the last means and the EOS counts arithmetically from the pass data.

// File: rtl/avg_pkg.sv
package avg_pkg;

    localparam int AVG_CNT_W = 8;

    typedef enum logic [1:0] {
        SEL_OFF = 2'b00,
        SEL_16  = 2'b01,
        SEL_64  = 2'b10,
        SEL_256 = 2'b11
    } depth_sel_e;

    function automatic logic [3:0] shift_of(depth_sel_e s);
        case (s)
            SEL_16:  return 4'd4;
            SEL_64:  return 4'd6;
            SEL_256: return 4'd8;
            default: return 4'd0;
        endcase
    endfunction

    function automatic logic [AVG_CNT_W-1:0] last_of(depth_sel_e s);
        case (s)
            SEL_16:  return 8'd15;
            SEL_64:  return 8'd63;
            SEL_256: return 8'd255;
            default: return 8'd0;
        endcase
    endfunction

endpackage

// File: rtl/avg_lane.sv
module avg_lane #(
    parameter int DATA_W = 16,
    parameter int ACC_W  = 24,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              hit_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic [CNT_W-1:0]  last_i,
    input  logic [3:0]        shift_i,
    output logic              fire_o,
    output logic [DATA_W-1:0] mean_o
);

    typedef struct packed {
        logic [ACC_W-1:0] acc;
        logic [CNT_W-1:0] cnt;
    } lane_t;

    lane_t st_q, st_d;
    logic [ACC_W-1:0] base_acc, sum;
    logic [CNT_W-1:0] base_cnt;

    always_comb begin
        base_acc = clr_i ? '0 : st_q.acc;
        base_cnt = clr_i ? '0 : st_q.cnt;
        sum      = base_acc + ACC_W'(data_i);
        fire_o   = hit_i && (base_cnt == last_i);
        mean_o   = DATA_W'(sum >> shift_i);
        st_d.acc = base_acc;
        st_d.cnt = base_cnt;
        if (hit_i) begin
            if (fire_o) begin
                st_d.acc = '0;
                st_d.cnt = '0;
            end else begin
                st_d.acc = sum;
                st_d.cnt = base_cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R3
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_i |-> (st_q.cnt <= last_i));

    // R8
    zero_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cnt == '0) |-> (st_q.acc == '0));

endmodule

// File: rtl/avg_eos_gen.sv
module avg_eos_gen #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             pass_end_i,
    input  logic             active_i,
    input  logic [CNT_W-1:0] last_i,
    output logic             eos_o
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             eos;
    } eos_t;

    eos_t st_q, st_d;
    logic [CNT_W-1:0] base_cnt;

    always_comb begin
        base_cnt   = clr_i ? '0 : st_q.cnt;
        st_d.cnt   = base_cnt;
        st_d.eos   = 1'b0;
        if (pass_end_i) begin
            if (!active_i) begin
                st_d.eos = 1'b1;
                st_d.cnt = '0;
            end else if (base_cnt == last_i) begin
                st_d.eos = 1'b1;
                st_d.cnt = '0;
            end else begin
                st_d.cnt = base_cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign eos_o = st_q.eos;

    // R5
    eos_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.eos |-> $past(pass_end_i));

    // R5
    pass_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_i |-> (st_q.cnt <= last_i));

endmodule

// File: rtl/avg_seq_acc.sv
module avg_seq_acc
    import avg_pkg::*;
#(
    parameter int NUM_CH    = 32,
    parameter int DATA_W    = 16,
    parameter int ACC_W     = 24,
    parameter int CAL_CH    = 8,
    parameter int CAL_SHIFT = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [1:0]                depth_sel,
    input  logic [NUM_CH-1:0]         avg_mask,
    input  logic                      cal_avg_n,
    input  logic                      res_valid,
    input  logic [$clog2(NUM_CH)-1:0] res_ch,
    input  logic [DATA_W-1:0]         res_data,
    input  logic                      pass_end,
    output logic                      st_we,
    output logic [$clog2(NUM_CH)-1:0] st_ch,
    output logic [DATA_W-1:0]         st_val,
    output logic                      cal_we,
    output logic [DATA_W-1:0]         cal_val,
    output logic                      eos
);

    localparam int CH_W = $clog2(NUM_CH);
    localparam int CNT_W = AVG_CNT_W;
    localparam logic [CNT_W-1:0] CAL_LAST = CNT_W'((1 << CAL_SHIFT) - 1);
    localparam logic [NUM_CH-1:0] CAL_BIT = NUM_CH'(1) << CAL_CH;

    typedef struct packed {
        logic              st_we;
        logic [CH_W-1:0]   st_ch;
        logic [DATA_W-1:0] st_val;
        logic              cal_we;
        logic [DATA_W-1:0] cal_val;
        logic              cal_first;
        logic [1:0]        sel;
        logic [NUM_CH-1:0] mask;
        logic              caln;
    } top_t;

    top_t st_q, st_d;

    depth_sel_e        sel_e;
    logic              cfg_chg;
    logic [NUM_CH-1:0] avg_on;
    logic              avg_active;
    logic              first_base;
    logic              is_cal;
    logic [CNT_W-1:0]  depth_last;
    logic [3:0]        depth_shift;
    logic [NUM_CH-1:0] lane_hit;
    logic [NUM_CH-1:0] lane_fire;
    logic [DATA_W-1:0] lane_mean [NUM_CH];

    always_comb begin
        sel_e       = depth_sel_e'(depth_sel);
        cfg_chg     = (depth_sel != st_q.sel) || (avg_mask != st_q.mask)
                      || (cal_avg_n != st_q.caln);
        avg_on      = (sel_e != SEL_OFF) ? (avg_mask & ~CAL_BIT) : '0;
        avg_active  = |avg_on;
        first_base  = cfg_chg ? 1'b0 : st_q.cal_first;
        is_cal      = (32'(res_ch) == CAL_CH);
        depth_last  = last_of(sel_e);
        depth_shift = shift_of(sel_e);
    end

    for (genvar i = 0; i < NUM_CH; i++) begin : g_lane
        if (i == CAL_CH) begin : g_cal
            assign lane_hit[i] = res_valid && is_cal && !cal_avg_n && first_base;
            avg_lane #(.DATA_W(DATA_W), .ACC_W(ACC_W), .CNT_W(CNT_W)) u_lane (
                .clk     (clk),
                .rst_n   (rst_n),
                .clr_i   (cfg_chg),
                .hit_i   (lane_hit[i]),
                .data_i  (res_data),
                .last_i  (CAL_LAST),
                .shift_i (4'(CAL_SHIFT)),
                .fire_o  (lane_fire[i]),
                .mean_o  (lane_mean[i])
            );
        end else begin : g_std
            assign lane_hit[i] = res_valid && (32'(res_ch) == i) && avg_on[i];
            avg_lane #(.DATA_W(DATA_W), .ACC_W(ACC_W), .CNT_W(CNT_W)) u_lane (
                .clk     (clk),
                .rst_n   (rst_n),
                .clr_i   (cfg_chg),
                .hit_i   (lane_hit[i]),
                .data_i  (res_data),
                .last_i  (depth_last),
                .shift_i (depth_shift),
                .fire_o  (lane_fire[i]),
                .mean_o  (lane_mean[i])
            );
        end
    end

    always_comb begin
        st_d           = st_q;
        st_d.st_we     = 1'b0;
        st_d.cal_we    = 1'b0;
        st_d.cal_first = first_base;
        st_d.sel       = depth_sel;
        st_d.mask      = avg_mask;
        st_d.caln      = cal_avg_n;
        if (res_valid) begin
            if (is_cal) begin
                if (cal_avg_n) begin
                    st_d.cal_we  = 1'b1;
                    st_d.cal_val = res_data;
                end else if (!first_base) begin
                    st_d.cal_we    = 1'b1;
                    st_d.cal_val   = res_data;
                    st_d.cal_first = 1'b1;
                end else if (lane_fire[res_ch]) begin
                    st_d.cal_we  = 1'b1;
                    st_d.cal_val = lane_mean[res_ch];
                end
            end else if (avg_on[res_ch]) begin
                if (lane_fire[res_ch]) begin
                    st_d.st_we  = 1'b1;
                    st_d.st_ch  = res_ch;
                    st_d.st_val = lane_mean[res_ch];
                end
            end else begin
                st_d.st_we  = 1'b1;
                st_d.st_ch  = res_ch;
                st_d.st_val = res_data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    avg_eos_gen #(.CNT_W(CNT_W)) u_eos (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr_i      (cfg_chg),
        .pass_end_i (pass_end),
        .active_i   (avg_active),
        .last_i     (depth_last),
        .eos_o      (eos)
    );

    assign st_we   = st_q.st_we;
    assign st_ch   = st_q.st_ch;
    assign st_val  = st_q.st_val;
    assign cal_we  = st_q.cal_we;
    assign cal_val = st_q.cal_val;

    // R6
    cal_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.st_we |-> (32'(st_q.st_ch) != CAL_CH));

    // R2
    st_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.st_we |-> $past(res_valid));

    // R6
    cal_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cal_we |-> $past(res_valid && is_cal));

    // R4
    off_passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && depth_sel == 2'b00 && !is_cal)
        |=> (st_q.st_we && st_q.st_val == $past(res_data)));

    // R6
    cal_raw_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && is_cal && cal_avg_n)
        |=> (st_q.cal_we && st_q.cal_val == $past(res_data)));

endmodule

// File: tb/tb_avg_seq_acc.sv
`timescale 1ns/1ps
module tb_avg_seq_acc;

    localparam int NCH = 4;
    localparam int CAL = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  sel = 2'b00;
    logic [3:0]  mask = 4'h0;
    logic        caln = 1'b1;
    logic        rv = 1'b0;
    logic [1:0]  rch = 2'd0;
    logic [15:0] rdat = 16'd0;
    logic        pe = 1'b0;
    logic        st_we, cal_we, eos;
    logic [1:0]  st_ch;
    logic [15:0] st_val, cal_val;

    int nchk = 0;
    int nerr = 0;
    bit fs = 1'b0;
    bit done = 1'b0;

    int          wr_cnt [NCH] = '{default: 0};
    logic [15:0] wr_last [NCH] = '{default: 16'd0};
    int          cal_cnt = 0;
    logic [15:0] cal_last = 16'd0;
    int          eos_cnt = 0;
    int          b_cnt [NCH];
    int          b_cal, b_eos;

    always #4 clk = ~clk;

    avg_seq_acc #(.NUM_CH(NCH), .CAL_CH(CAL)) dut (
        .clk(clk), .rst_n(rst_n), .depth_sel(sel), .avg_mask(mask),
        .cal_avg_n(caln), .res_valid(rv), .res_ch(rch), .res_data(rdat),
        .pass_end(pe), .st_we(st_we), .st_ch(st_ch), .st_val(st_val),
        .cal_we(cal_we), .cal_val(cal_val), .eos(eos)
    );

    always @(negedge clk) begin
        if (rst_n) begin
            if (st_we) begin
                wr_cnt[st_ch] = wr_cnt[st_ch] + 1;
                wr_last[st_ch] = st_val;
            end
            if (cal_we) begin
                cal_cnt = cal_cnt + 1;
                cal_last = cal_val;
            end
            if (eos) eos_cnt = eos_cnt + 1;
        end
    end

    function automatic logic [15:0] dval(int ch, int p);
        if (fs) return 16'hFFFF;
        return 16'((ch * 9973 + p * 613 + 17) % 65536);
    endfunction

    task automatic check(bit ok, string req, string what, int act, int exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic send(int ch, logic [15:0] d);
        @(negedge clk);
        rv = 1'b1; rch = 2'(ch); rdat = d;
        @(negedge clk);
        rv = 1'b0;
    endtask

    task automatic end_pass();
        @(negedge clk);
        pe = 1'b1;
        @(negedge clk);
        pe = 1'b0;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic snap();
        for (int c = 0; c < NCH; c++) b_cnt[c] = wr_cnt[c];
        b_cal = cal_cnt;
        b_eos = eos_cnt;
    endtask

    task automatic run_passes(int p0, int n);
        for (int p = p0; p < p0 + n; p++) begin
            for (int c = 0; c < NCH; c++) send(c, dval(c, p));
            end_pass();
        end
        idle(3);
    endtask

    task automatic start(logic [1:0] s, logic [3:0] m, logic cn);
        @(negedge clk);
        rst_n = 1'b0; sel = s; mask = m; caln = cn;
        idle(3);
        rst_n = 1'b1;
        idle(2);
        snap();
    endtask

    task automatic expect_all(string tag, logic [1:0] s, logic [3:0] m,
                              logic cn, int p0, int n);
        int sh, nn, full, wr, ex_eos;
        longint sum;
        logic [15:0] ex_last;
        sh = (s == 2'd1) ? 4 : (s == 2'd2) ? 6 : (s == 2'd3) ? 8 : 0;
        nn = 1 << sh;
        for (int c = 0; c < NCH; c++) begin
            if (c == CAL) continue;
            if (s != 2'd0 && m[c]) begin
                full = n / nn;
                sum = 0;
                for (int p = p0 + (full - 1) * nn; p < p0 + full * nn; p++)
                    sum += longint'(dval(c, p));
                ex_last = 16'(sum >> sh);
                check(wr_cnt[c] - b_cnt[c] == full, {tag, " R3"}, $sformatf("ch%0d writes", c),
                      wr_cnt[c] - b_cnt[c], full);
                if (full > 0)
                    check(wr_last[c] == ex_last, {tag, " R3"}, $sformatf("ch%0d mean", c),
                          int'(wr_last[c]), int'(ex_last));
            end else begin
                check(wr_cnt[c] - b_cnt[c] == n, {tag, " R2 R11"}, $sformatf("ch%0d writes", c),
                      wr_cnt[c] - b_cnt[c], n);
                check(wr_last[c] == dval(c, p0 + n - 1), {tag, " R2"}, $sformatf("ch%0d value", c),
                      int'(wr_last[c]), int'(dval(c, p0 + n - 1)));
            end
        end
        check(wr_cnt[CAL] - b_cnt[CAL] == 0, {tag, " R6"}, "status writes on cal channel",
              wr_cnt[CAL] - b_cnt[CAL], 0);
        if (cn) begin
            wr = n;
            ex_last = dval(CAL, p0 + n - 1);
        end else begin
            wr = 1 + (n - 1) / 16;
            if (wr > 1) begin
                sum = 0;
                for (int p = p0 + 1 + (wr - 2) * 16; p < p0 + 1 + (wr - 1) * 16; p++)
                    sum += longint'(dval(CAL, p));
                ex_last = 16'(sum >> 4);
            end else begin
                ex_last = dval(CAL, p0);
            end
        end
        check(cal_cnt - b_cal == wr, {tag, " R6 R7"}, "cal writes", cal_cnt - b_cal, wr);
        check(cal_last == ex_last, {tag, " R6 R7"}, "cal value", int'(cal_last), int'(ex_last));
        ex_eos = (s != 2'd0 && (m & 4'b0111) != 4'd0) ? n / nn : n;
        check(eos_cnt - b_eos == ex_eos, {tag, " R5"}, "eos count", eos_cnt - b_eos, ex_eos);
    endtask

    task automatic scenario(string tag, logic [1:0] s, logic [3:0] m, logic cn, int n);
        start(s, m, cn);
        run_passes(0, n);
        expect_all(tag, s, m, cn, 0, n);
    endtask

    initial begin
        idle(2);
        // R1: outputs quiet in and right after reset
        check(!st_we && !cal_we && !eos, "R1", "outputs in reset", int'({st_we, cal_we, eos}), 0);
        @(negedge clk);
        rst_n = 1'b1;
        idle(2);
        check(!st_we && !cal_we && !eos, "R1", "outputs after reset", int'({st_we, cal_we, eos}), 0);

        scenario("R4 off", 2'd0, 4'hF, 1'b1, 20);
        scenario("R11 avg16", 2'd1, 4'b0010, 1'b0, 40);
        scenario("avg64", 2'd2, 4'b0011, 1'b1, 130);
        scenario("avg256", 2'd3, 4'b0101, 1'b0, 260);
        scenario("R9 calbit", 2'd1, 4'b1000, 1'b1, 20);
        fs = 1'b1;
        scenario("R10 fullscale", 2'd3, 4'b0001, 1'b1, 256);
        fs = 1'b0;

        // R8: partial block, then a config change and restore
        start(2'd1, 4'b0001, 1'b0);
        run_passes(0, 5);
        sel = 2'd2;
        idle(2);
        sel = 2'd1;
        idle(2);
        snap();
        run_passes(5, 16);
        expect_all("R8 clear", 2'd1, 4'b0001, 1'b0, 5, 16);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            nchk++;
            nerr++;
            $display("FAIL R1 watchdog: got %0d expected %0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

endmodule